// File: doc/BRIEF.md
# Mask-Gated SAD Motion Search

This block finds the best match for one square block of current-frame pixels inside a reference search window. For every candidate displacement it forms a sum of absolute pixel differences, in which only the positions selected by a per-pixel enable mask count. It then reports the displacement with the smallest sum and that sum. The mask is usually made from edge pixels merged with a regular subsample pattern. The denser the mask, the more arithmetic switches, so power follows mask density.

The datapath is one row of N difference elements that is reused for every block row of every candidate. The block drives a read request for one current-block row and one reference-window row segment each cycle. The surrounding memory returns both rows on the next cycle. An element whose mask bit is clear keeps its operand registers frozen and feeds zero into the row adder. The read schedule, the cycle count and the control sequence are the same for every mask. The power mode can therefore change from one search to the next with no other effect.

Top module: `msad_search`

## Requirements
- R1: For each candidate (u, v), the cost is the sum over rows i and columns j in 0..N-1 of mask(i,j)·|S(i+u+P, j+v+P) − C(i,j)|, where S is the reference window of N+2P−1 square and C is the current block. `min_cost` reports the smallest cost over all candidates.
- R2: Candidates cover −P ≤ u, v ≤ P−1. `mv_row` carries u and `mv_col` carries v, both in two's complement.
- R3: When costs are equal, the earlier candidate is kept. The order is v outer and u inner, each ascending from −P.
- R4: A position whose mask bit is 0 adds nothing to any cost. Its current-pixel value has no effect on the results, and an all-zero mask yields cost 0 and (−P, −P). Mask bit i·N+j belongs to row i, column j.
- R5: The mask is sampled only on the edge that accepts a start. Changes on `mask_in` during the search have no effect.
- R6: `rd_en` is high for exactly 4P²N consecutive cycles, starting in the cycle after the start edge. Request k (counted from 0) has `rd_cur_row` = k mod N, u+P = (k/N) mod 2P and v+P = k/(2PN), with `rd_ref_row` = (k mod N)+u+P and `rd_ref_col` = v+P. This is the same for every mask. Data for a request are taken from `cur_pix`/`ref_pix` in the next cycle, with pixel j at bits [8j+7:8j] and the reference segment starting at column `rd_ref_col`.
- R7: `done` is a one-cycle pulse visible 4P²N+2 clock edges after the start edge. `busy` is high from the start edge until that cycle and low in it. `mv_row`, `mv_col` and `min_cost` change only when `done` is raised, and hold afterwards.
- R8: A start raised while `busy` is high is ignored: it changes neither the schedule nor the result.
- R9: The cost path does not overflow. N²·255 is reported exactly.
- R10: During reset `busy`, `done` and `rd_en` are 0, `min_cost` is 0, and both vector components are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| mask_in | input | N·N | Per-pixel enable mask, bit i·N+j |
| busy | output | 1 | Search in progress |
| rd_en | output | 1 | Row read request |
| rd_cur_row | output | clog2(N) | Current-block row to return |
| rd_ref_row | output | clog2(N+2P−1) | Reference-window row to return |
| rd_ref_col | output | clog2(N+2P−1) | First reference-window column of the segment |
| cur_pix | input | 8·N | Current-block row, returned one cycle after the request |
| ref_pix | input | 8·N | Reference row segment, returned one cycle after the request |
| done | output | 1 | Result valid pulse |
| mv_row | output | clog2(2P) | Row displacement u (signed) |
| mv_col | output | clog2(2P) | Column displacement v (signed) |
| min_cost | output | clog2(N²·255+1) | Minimum masked sum |

## Verification
The bench builds the block with N = 4 and P = 2. That gives 16 candidates, a 7×7 window and a 64-cycle read schedule. With these values every candidate sum can be recomputed in the bench for each run. The exact request sequence and the done latency can be compared cycle by cycle for every mask tried. The small size also brings the extreme displacements, the full-scale cost of 4080 in a 12-bit result, and deliberately built ties along either axis within reach of direct checks.

// File: rtl/msad_pkg.sv
package msad_pkg;
  localparam int PIX_W   = 8;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/msad_ctrl.sv
module msad_ctrl #(
  parameter  int N  = 16,
  parameter  int P  = 8,
  localparam int RW = $clog2(N),
  localparam int UW = $clog2(2*P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          issue,
  output logic [RW-1:0] row,
  output logic [UW-1:0] du,
  output logic [UW-1:0] dv,
  output logic          first_row,
  output logic          last_row,
  output logic          first_cand,
  output logic          last_cand
);
  localparam logic [RW-1:0] ROW_END = RW'(N-1);
  localparam logic [UW-1:0] D_END   = UW'(2*P-1);

  logic          act_q, act_d;
  logic [RW-1:0] row_q, row_d;
  logic [UW-1:0] du_q, du_d, dv_q, dv_d;

  always_comb begin
    act_d = act_q;
    row_d = row_q;
    du_d  = du_q;
    dv_d  = dv_q;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        row_d = '0;
        du_d  = '0;
        dv_d  = '0;
      end
    end else if (row_q == ROW_END) begin
      row_d = '0;
      if (du_q == D_END) begin
        du_d = '0;
        if (dv_q == D_END) begin
          dv_d  = '0;
          act_d = 1'b0;
        end else begin
          dv_d = dv_q + 1'b1;
        end
      end else begin
        du_d = du_q + 1'b1;
      end
    end else begin
      row_d = row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      row_q <= '0;
      du_q  <= '0;
      dv_q  <= '0;
    end else begin
      act_q <= act_d;
      row_q <= row_d;
      du_q  <= du_d;
      dv_q  <= dv_d;
    end
  end

  assign issue      = act_q;
  assign row        = row_q;
  assign du         = du_q;
  assign dv         = dv_q;
  assign first_row  = (row_q == '0);
  assign last_row   = (row_q == ROW_END);
  assign first_cand = (du_q == '0) && (dv_q == '0);
  assign last_cand  = (du_q == D_END) && (dv_q == D_END);

  // R6: rows advance one per cycle within a candidate
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !last_row) |=> (issue && row == $past(row) + 1'b1));

  // R6: a finished candidate wraps to row 0 of the next one
  p_row_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && last_row && !last_cand) |=> (issue && row == '0));
endmodule

// File: rtl/msad_pe.sv
module msad_pe import msad_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  pix_t cur,
  input  pix_t rf,
  output pix_t diff
);
  pix_t a_q, a_d, b_q, b_d;
  logic on_q;

  always_comb begin
    a_d = load ? cur : a_q;
    b_d = load ? rf  : b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      on_q <= 1'b0;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      on_q <= load;
    end
  end

  assign diff = on_q ? ((a_q > b_q) ? (a_q - b_q) : (b_q - a_q)) : '0;
endmodule

// File: rtl/msad_rowsum.sv
module msad_rowsum import msad_pkg::*; #(
  parameter  int N  = 16,
  localparam int SW = $clog2(N*PIX_MAX+1)
) (
  input  logic [N*PIX_W-1:0] diffs,
  output logic [SW-1:0]      sum
);
  always_comb begin
    sum = '0;
    for (int j = 0; j < N; j++) begin
      sum = sum + SW'(diffs[j*PIX_W +: PIX_W]);
    end
  end
endmodule

// File: rtl/msad_best.sv
module msad_best #(
  parameter int P  = 8,
  parameter int UW = 4,
  parameter int SW = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          first_row,
  input  logic          last_row,
  input  logic          first_cand,
  input  logic          last_cand,
  input  logic [UW-1:0] du,
  input  logic [UW-1:0] dv,
  input  logic [SW-1:0] rowsum,
  output logic          done,
  output logic [CW-1:0] cost,
  output logic [UW-1:0] best_u,
  output logic [UW-1:0] best_v
);
  logic [CW-1:0] acc_q, acc_d, run_q, run_d, out_q, out_d;
  logic [UW-1:0] ru_q, ru_d, rv_q, rv_d, ou_q, ou_d, ov_q, ov_d;
  logic [CW-1:0] base, total;
  logic          better, close, fin, done_q;

  always_comb begin
    base   = first_row ? '0 : acc_q;
    total  = base + CW'(rowsum);
    better = first_cand || (total < run_q);
    close  = valid && last_row;
    fin    = close && last_cand;
    acc_d  = valid ? total : acc_q;
    run_d  = run_q;
    ru_d   = ru_q;
    rv_d   = rv_q;
    if (close && better) begin
      run_d = total;
      ru_d  = du;
      rv_d  = dv;
    end
    out_d = out_q;
    ou_d  = ou_q;
    ov_d  = ov_q;
    if (fin) begin
      out_d = run_d;
      ou_d  = ru_d;
      ov_d  = rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      run_q  <= '0;
      ru_q   <= '0;
      rv_q   <= '0;
      out_q  <= '0;
      ou_q   <= UW'(P);
      ov_q   <= UW'(P);
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      run_q  <= run_d;
      ru_q   <= ru_d;
      rv_q   <= rv_d;
      out_q  <= out_d;
      ou_q   <= ou_d;
      ov_q   <= ov_d;
      done_q <= fin;
    end
  end

  assign done   = done_q;
  assign cost   = out_q;
  assign best_u = ou_q;
  assign best_v = ov_q;

  // R9: adding a row never wraps the accumulator
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (total >= base));

  // R1: the running minimum never grows within a search
  p_min_monotone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !first_cand) |=> (run_q <= $past(run_q)));

  // R7: the completion flag is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: reported results move only together with the completion flag
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q && !$past(fin) |-> ($stable(out_q) && $stable(ou_q) && $stable(ov_q)));
endmodule

// File: rtl/msad_search.sv
module msad_search import msad_pkg::*; #(
  parameter  int N   = 16,
  parameter  int P   = 8,
  localparam int NN  = N*N,
  localparam int WIN = N + 2*P - 1,
  localparam int RW  = $clog2(N),
  localparam int UW  = $clog2(2*P),
  localparam int WW  = $clog2(WIN),
  localparam int SW  = $clog2(N*PIX_MAX+1),
  localparam int CW  = $clog2(NN*PIX_MAX+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NN-1:0]        mask_in,
  output logic                 busy,
  output logic                 rd_en,
  output logic [RW-1:0]        rd_cur_row,
  output logic [WW-1:0]        rd_ref_row,
  output logic [WW-1:0]        rd_ref_col,
  input  logic [N*PIX_W-1:0]   cur_pix,
  input  logic [N*PIX_W-1:0]   ref_pix,
  output logic                 done,
  output logic signed [UW-1:0] mv_row,
  output logic signed [UW-1:0] mv_col,
  output logic [CW-1:0]        min_cost
);
  logic          accept, issue;
  logic [RW-1:0] row0, row1;
  logic [UW-1:0] du0, dv0, du1, dv1, du2, dv2;
  logic          fr0, lr0, fc0, lc0;
  logic          v1, fr1, lr1, fc1, lc1;
  logic          v2, fr2, lr2, fc2, lc2;
  logic [NN-1:0] mask_q;
  logic [N-1:0]  mrow1, mrow2, load;
  logic [N*PIX_W-1:0] diffs;
  logic [SW-1:0] rsum;
  logic [UW-1:0] best_u, best_v;

  assign busy   = issue | v1 | v2;
  assign accept = start & ~busy;

  msad_ctrl #(.N(N), .P(P)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(accept), .issue(issue), .row(row0),
    .du(du0), .dv(dv0), .first_row(fr0), .last_row(lr0),
    .first_cand(fc0), .last_cand(lc0)
  );

  assign rd_en      = issue;
  assign rd_cur_row = row0;
  assign rd_ref_row = WW'(row0) + WW'(du0);
  assign rd_ref_col = WW'(dv0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (accept) begin
      mask_q <= mask_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; fr1 <= 1'b0; lr1 <= 1'b0; fc1 <= 1'b0; lc1 <= 1'b0;
      row1 <= '0; du1 <= '0; dv1 <= '0;
      v2 <= 1'b0; fr2 <= 1'b0; lr2 <= 1'b0; fc2 <= 1'b0; lc2 <= 1'b0;
      du2 <= '0; dv2 <= '0; mrow2 <= '0;
    end else begin
      v1 <= issue; fr1 <= fr0; lr1 <= lr0; fc1 <= fc0; lc1 <= lc0;
      row1 <= row0; du1 <= du0; dv1 <= dv0;
      v2 <= v1; fr2 <= fr1; lr2 <= lr1; fc2 <= fc1; lc2 <= lc1;
      du2 <= du1; dv2 <= dv1;
      mrow2 <= v1 ? mrow1 : '0;
    end
  end

  assign mrow1 = mask_q[int'(row1)*N +: N];

  for (genvar j = 0; j < N; j++) begin : g_pe
    assign load[j] = v1 & mrow1[j];
    msad_pe u_pe (
      .clk(clk), .rst_n(rst_n), .load(load[j]),
      .cur(cur_pix[j*PIX_W +: PIX_W]), .rf(ref_pix[j*PIX_W +: PIX_W]),
      .diff(diffs[j*PIX_W +: PIX_W])
    );

    // R4: an element left off by the mask feeds zero to the row sum
    p_gate_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !mrow2[j]) |-> (diffs[j*PIX_W +: PIX_W] == '0));
  end

  msad_rowsum #(.N(N)) u_sum (.diffs(diffs), .sum(rsum));

  msad_best #(.P(P), .UW(UW), .SW(SW), .CW(CW)) u_best (
    .clk(clk), .rst_n(rst_n), .valid(v2), .first_row(fr2), .last_row(lr2),
    .first_cand(fc2), .last_cand(lc2), .du(du2), .dv(dv2), .rowsum(rsum),
    .done(done), .cost(min_cost), .best_u(best_u), .best_v(best_v)
  );

  assign mv_row = $signed(best_u - UW'(P));
  assign mv_col = $signed(best_v - UW'(P));

  // R6: an accepted start opens the schedule at the first request
  p_sched_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rd_en && rd_cur_row == '0 && rd_ref_row == '0 && rd_ref_col == '0));

  // R7: completion is flagged only once the search has drained
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: the reported vector lies inside the search range
  p_mv_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mv_row >= -P && mv_row <= P-1 && mv_col >= -P && mv_col <= P-1));
endmodule

// File: tb/sim_msad_search.sv
`timescale 1ns/1ps
module sim_msad_search;
  localparam int N   = 4;
  localparam int P   = 2;
  localparam int NN  = N*N;
  localparam int WIN = N + 2*P - 1;
  localparam int RW  = $clog2(N);
  localparam int UW  = $clog2(2*P);
  localparam int WW  = $clog2(WIN);
  localparam int CW  = $clog2(NN*255+1);
  localparam int K   = 4*P*P*N;

  logic clk, rst_n, start, busy, rd_en, done;
  logic [NN-1:0] mask_in;
  logic [RW-1:0] rd_cur_row;
  logic [WW-1:0] rd_ref_row, rd_ref_col;
  logic [N*8-1:0] cur_pix, ref_pix;
  logic signed [UW-1:0] mv_row, mv_col;
  logic [CW-1:0] min_cost;

  logic [7:0] cur_mem [N][N];
  logic [7:0] ref_mem [WIN][WIN];

  int checks = 0;
  int errors = 0;
  int got_cost, got_u, got_v;

  msad_search #(.N(N), .P(P)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_in(mask_in), .busy(busy),
    .rd_en(rd_en), .rd_cur_row(rd_cur_row), .rd_ref_row(rd_ref_row),
    .rd_ref_col(rd_ref_col), .cur_pix(cur_pix), .ref_pix(ref_pix),
    .done(done), .mv_row(mv_row), .mv_col(mv_col), .min_cost(min_cost)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // row memory with one cycle of read latency
  always @(posedge clk) begin
    if (rd_en) begin
      for (int j = 0; j < N; j++) begin
        cur_pix[j*8 +: 8] <= cur_mem[rd_cur_row][j];
        ref_pix[j*8 +: 8] <= ref_mem[rd_ref_row][int'(rd_ref_col) + j];
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_result(input logic [NN-1:0] m, output int ec,
                            output int eu, output int ev);
    int s;
    ec = -1; eu = 0; ev = 0;
    for (int v = 0; v < 2*P; v++) begin
      for (int u = 0; u < 2*P; u++) begin
        s = 0;
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < N; j++) begin
            if (m[i*N+j]) begin
              int d;
              d = int'(ref_mem[i+u][j+v]) - int'(cur_mem[i][j]);
              s += (d < 0) ? -d : d;
            end
          end
        end
        if (ec < 0 || s < ec) begin
          ec = s; eu = u - P; ev = v - P;
        end
      end
    end
  endtask

  task automatic run_block(input logic [NN-1:0] m, input bit poke, input string req);
    int n, lat, ec, eu, ev;
    bit seq_ok, busy_ok;
    ref_result(m, ec, eu, ev);
    @(negedge clk);
    mask_in = m;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    mask_in = ~m;  // R5: later mask changes must be ignored
    n = 0; lat = -1; seq_ok = 1'b1; busy_ok = 1'b1;
    while (lat < 0 && n < K + 8) begin
      if (rd_en !== (n < K)) seq_ok = 1'b0;
      if (n < K) begin
        int i, u, v;
        i = n % N; u = (n / N) % (2*P); v = n / (N*2*P);
        if (rd_cur_row !== RW'(i) || rd_ref_row !== WW'(i+u) || rd_ref_col !== WW'(v))
          seq_ok = 1'b0;
      end
      if (busy !== (n <= K + 1)) busy_ok = 1'b0;
      if (done) lat = n;
      else begin
        start = (poke && n == 5);  // R8: start while busy
        @(posedge clk);
        @(negedge clk);
        n++;
      end
    end
    start = 1'b0;
    chk(seq_ok, "R6", "read schedule matches", int'(seq_ok), 1);
    chk(lat == K + 2, "R7", "done latency", lat, K + 2);
    chk(busy_ok, "R7", "busy window", int'(busy_ok), 1);
    got_cost = int'(min_cost); got_u = int'(mv_row); got_v = int'(mv_col);
    chk(got_cost == ec, req, "min_cost", got_cost, ec);
    chk(got_u == eu, req, "mv_row", got_u, eu);
    chk(got_v == ev, req, "mv_col", got_v, ev);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", int'(done), 0);
    repeat (2) @(negedge clk);
    chk(int'(min_cost) == got_cost && int'(mv_row) == got_u && int'(mv_col) == got_v,
        "R7", "results held", int'(min_cost), got_cost);
  endtask

  task automatic fill_random;
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) ref_mem[y][x] = 8'($urandom);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) cur_mem[i][j] = 8'($urandom);
  endtask

  task automatic plant(input int u, input int v);
    fill_random();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) cur_mem[i][j] = ref_mem[i+u+P][j+v+P];
  endtask

  initial begin
    logic [NN-1:0] m, chess;
    int sc, su, sv;
    rst_n = 1'b0; start = 1'b0; mask_in = '0;
    for (int y = 0; y < WIN; y++) for (int x = 0; x < WIN; x++) ref_mem[y][x] = '0;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cur_mem[i][j] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0, "R10", "busy", int'(busy), 0);
    chk(done == 1'b0, "R10", "done", int'(done), 0);
    chk(rd_en == 1'b0, "R10", "rd_en", int'(rd_en), 0);
    chk(min_cost == '0, "R10", "min_cost", int'(min_cost), 0);
    chk(mv_row == 0 && mv_col == 0, "R10", "vector", int'(mv_row), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: random content, full mask and random masks
    for (int t = 0; t < 3; t++) begin
      fill_random();
      run_block('1, 1'b0, "R1");
    end
    for (int t = 0; t < 3; t++) begin
      fill_random();
      run_block(NN'($urandom), 1'b0, "R1");
    end

    // R2: planted exact matches, including both range corners
    plant(1, -1);
    run_block('1, 1'b0, "R2");
    chk(got_u == 1 && got_v == -1 && got_cost == 0, "R2", "planted (1,-1)", got_u, 1);
    plant(-P, -P);
    run_block('1, 1'b0, "R2");
    chk(got_u == -P && got_v == -P && got_cost == 0, "R2", "planted corner low", got_u, -P);
    plant(P-1, P-1);
    run_block('1, 1'b0, "R2");
    chk(got_u == P-1 && got_v == P-1 && got_cost == 0, "R2", "planted corner high", got_v, P-1);

    // R4: checkerboard mask, then masked-out pixels rewritten
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) chess[i*N+j] = ((i + j) % 2 == 0);
    fill_random();
    run_block(chess, 1'b0, "R4");
    m = NN'($urandom);
    fill_random();
    run_block(m, 1'b0, "R4");
    sc = got_cost; su = got_u; sv = got_v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) if (!m[i*N+j]) cur_mem[i][j] = 8'($urandom);
    run_block(m, 1'b0, "R4");
    chk(got_cost == sc && got_u == su && got_v == sv, "R4", "masked pixels ignored", got_cost, sc);
    fill_random();
    run_block('0, 1'b0, "R4");
    chk(got_cost == 0 && got_u == -P && got_v == -P, "R4", "empty mask", got_cost, 0);

    // R3: ties along u (cost independent of row offset)
    for (int y = 0; y < WIN; y++) for (int x = 0; x < WIN; x++)
      ref_mem[y][x] = 8'(10 * ((x > 3) ? x - 3 : 3 - x));
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
      cur_mem[i][j] = 8'(10 * ((j + 2 > 3) ? j + 2 - 3 : 3 - j - 2));
    run_block('1, 1'b0, "R3");
    chk(got_u == -P && got_v == 0, "R3", "tie along u keeps first", got_u, -P);
    // R3: ties along v (cost independent of column offset)
    for (int y = 0; y < WIN; y++) for (int x = 0; x < WIN; x++)
      ref_mem[y][x] = 8'(10 * ((y > 3) ? y - 3 : 3 - y));
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cur_mem[i][j] = 8'(10 * i);
    run_block('1, 1'b0, "R3");
    chk(got_u == 1 && got_v == -P, "R3", "tie along v keeps first", got_v, -P);

    // R9: full-scale cost
    for (int y = 0; y < WIN; y++) for (int x = 0; x < WIN; x++) ref_mem[y][x] = 8'hFF;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cur_mem[i][j] = 8'h00;
    run_block('1, 1'b0, "R9");
    chk(got_cost == NN*255, "R9", "max cost exact", got_cost, NN*255);

    // R8: start pulse in the middle of a search
    fill_random();
    run_block(NN'($urandom), 1'b1, "R8");

    // R5: sparse mask, scrambled to nearly full after acceptance
    fill_random();
    run_block(NN'(1) << 5, 1'b0, "R5");
    fill_random();
    run_block(16'h8001, 1'b0, "R5");

    summary();
    $finish;
  end
endmodule